// File: doc/BRIEF.md
# Transmit FIFO DMA Request Controller

This block drives the DMA request line of a transmit FIFO and decides which bus write cycles put a byte into that FIFO. Software first loads the length of the message block to send. The block then raises a level request for a DMA controller that runs in demand transfer mode. Each accepted write strobe edge produces a one-cycle FIFO write enable and lowers the count of bytes still owed. A bus cycle counts as a FIFO access when the shared acknowledge input is active, and the chip-select strobe is then ignored. Without acknowledge, the cycle counts only when the chip-select strobe is active, as in a memory-to-memory transfer. The receive side has its own request line and is not part of this block.

A demand-mode controller reacts to the request with some delay. To keep a controller of any speed from writing one byte too many, the request is pulled low one byte early: at the write of the second-to-last byte of the block, and at the write of the 31st byte of every 32-byte chunk. The controller may still complete the byte in flight. The request comes back on the next rising edge of acknowledge or chip select, but only if more than that in-flight byte remains. After the final byte of the block the request stays low until a new length is loaded.

The write, acknowledge and chip-select strobes are asynchronous to the system clock. Each passes through a synchronizer and an edge detector. The length load is a system-clock pulse.

Top module: `dma_tx_req_ctrl`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, dma_req and fifo_we are 0 and the remaining count is 0.
- R2: A load_count pulse takes priority over everything else in its cycle. It sets the remaining count to load_len and restarts the chunk position at zero. From the next cycle dma_req is 1 if load_len is nonzero and 0 if it is zero. A load in the middle of a block replaces the old count.
- R3: While dack is 1, a rising edge of wr_strobe with a nonzero remaining count gives exactly one cycle of fifo_we and lowers the count by one, whatever the level of cs_strobe.
- R4: While dack is 0, a write edge is accepted only when cs_strobe is 1. A write edge with both dack and cs_strobe at 0 gives no fifo_we and leaves the count unchanged.
- R5: The write accepted when the remaining count is 2 (transfer n-1 of the block) drives dma_req to 0.
- R6: The write of the 31st byte of any 32-byte chunk, counted from the last load, drives dma_req to 0 when more than one byte remains.
- R7: After an early drop, the next rising edge of dack sets dma_req to 1 again if more than one byte remains at that moment.
- R8: After an early drop, the next rising edge of cs_strobe re-arms dma_req in the same way as R7.
- R9: After an early drop, the byte in flight is accepted even though dma_req is 0. When that byte is the last of the block, dma_req stays 0, and later dack or cs_strobe edges do not raise it until the next load.
- R10: With a remaining count of 0, write edges give no fifo_we.
- R11: Each strobe is sampled through SYNC_STAGES flops, then edge-detected. With the default of 2, fifo_we and dma_req change after the third rising clock edge that samples the new strobe level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_strobe | input | 1 | Bus write strobe, active high, asynchronous |
| dack | input | 1 | Shared DMA acknowledge, active high, asynchronous |
| cs_strobe | input | 1 | FIFO chip-select strobe, active high, asynchronous |
| load_count | input | 1 | One-cycle pulse that loads a new block length |
| load_len | input | LEN_W | Block length in bytes |
| dma_req | output | 1 | Level DMA request for the transmit FIFO |
| fifo_we | output | 1 | One-cycle write enable into the transmit FIFO |

## Verification
A wrong remaining count or chunk position shows up as dma_req falling on the wrong write. The error reaches the ports three clocks after the strobe edge of that write, well before the controller could issue another byte. A stuck or missing re-arm flag shows at the next dack or cs_strobe rising edge, as a request that fails to return or one that returns after the final byte. A wrong select decode shows as an extra or missing fifo_we pulse in the same three-clock window.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
    localparam int unsigned CHUNK_BYTES = 32;
    localparam int unsigned POS_W       = $clog2(CHUNK_BYTES);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ACK  = 2'd1,
        SRC_CS   = 2'd2
    } cycle_src_e;
endpackage

// File: rtl/dmareq_sync.sv
module dmareq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
endmodule

// File: rtl/dmareq_decode.sv
module dmareq_decode
    import dmareq_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic             ack_lvl,
    input  logic             cs_lvl,
    input  logic             wr_rise,
    input  logic [LEN_W-1:0] remaining,
    output cycle_src_e       src,
    output logic             accept
);
    always_comb begin
        if (ack_lvl)     src = SRC_ACK;
        else if (cs_lvl) src = SRC_CS;
        else             src = SRC_NONE;
        accept = wr_rise && (src != SRC_NONE) && (remaining != '0);
    end
endmodule

// File: rtl/dma_tx_req_ctrl.sv
module dma_tx_req_ctrl
    import dmareq_pkg::*;
#(
    parameter int unsigned LEN_W       = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_strobe,
    input  logic             dack,
    input  logic             cs_strobe,
    input  logic             load_count,
    input  logic [LEN_W-1:0] load_len,
    output logic             dma_req,
    output logic             fifo_we
);
    localparam int unsigned N_STROBES = 3;
    localparam logic [POS_W-1:0] POS_EARLY = POS_W'(CHUNK_BYTES - 2);
    localparam logic [LEN_W-1:0] ONE_LEFT  = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO_LEFT  = LEN_W'(2);

    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic [POS_W-1:0] pos;
        logic             req;
        logic             hold;
        logic             we;
    } ctrl_t;

    ctrl_t st_d, st_q;

    // strobe synchronizers: index 0 write, 1 acknowledge, 2 chip select
    logic [N_STROBES-1:0] raw_vec, lvl_vec, rise_vec;
    assign raw_vec = {cs_strobe, dack, wr_strobe};

    generate
        for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
            dmareq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst   (rst),
                .d     (raw_vec[g]),
                .level (lvl_vec[g]),
                .rise  (rise_vec[g])
            );
        end
    endgenerate

    logic       wr_rise, ack_lvl, cs_lvl, ack_rise, cs_rise;
    assign wr_rise  = rise_vec[0];
    assign ack_lvl  = lvl_vec[1];
    assign ack_rise = rise_vec[1];
    assign cs_lvl   = lvl_vec[2];
    assign cs_rise  = rise_vec[2];

    cycle_src_e cyc_src;
    logic       accept;
    logic       lvl_wr_unused;
    assign lvl_wr_unused = lvl_vec[0];

    dmareq_decode #(.LEN_W(LEN_W)) u_decode (
        .ack_lvl   (ack_lvl),
        .cs_lvl    (cs_lvl),
        .wr_rise   (wr_rise),
        .remaining (st_q.rem),
        .src       (cyc_src),
        .accept    (accept)
    );

    logic cycle_selected;
    assign cycle_selected = (cyc_src != SRC_NONE);

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (load_count) begin
            st_d.rem  = load_len;
            st_d.pos  = '0;
            st_d.req  = (load_len != '0);
            st_d.hold = 1'b0;
        end else if (accept) begin
            st_d.we  = 1'b1;
            st_d.rem = st_q.rem - ONE_LEFT;
            st_d.pos = st_q.pos + 1'b1;
            if (st_q.rem == ONE_LEFT) begin
                st_d.req  = 1'b0;
                st_d.hold = 1'b0;
            end else if (st_q.rem == TWO_LEFT || st_q.pos == POS_EARLY) begin
                st_d.req  = 1'b0;
                st_d.hold = 1'b1;
            end
        end else if (st_q.hold && (ack_rise || cs_rise)) begin
            st_d.hold = 1'b0;
            st_d.req  = (st_q.rem > ONE_LEFT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // observation points for the bound checker
    logic [LEN_W-1:0] rem_q;
    logic             hold_q;
    assign rem_q  = st_q.rem;
    assign hold_q = st_q.hold;

    assign dma_req = st_q.req;
    assign fifo_we = st_q.we;
endmodule

// File: rtl/dmareq_checker.sv
module dmareq_checker #(
    parameter int unsigned LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             load_count,
    input logic [LEN_W-1:0] load_len,
    input logic             dma_req,
    input logic             fifo_we,
    input logic [LEN_W-1:0] rem_q,
    input logic             hold_q,
    input logic             selected,
    input logic             ack_rise,
    input logic             cs_rise,
    input logic             wr_level
);
    logic unused_ok;
    assign unused_ok = hold_q ^ wr_level;

    a_r2_load_arms: assert property (@(posedge clk) disable iff (rst)
        (load_count && load_len != '0) |=> dma_req);

    a_r2_load_zero: assert property (@(posedge clk) disable iff (rst)
        (load_count && load_len == '0) |=> !dma_req);

    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> (rem_q == LEN_W'($past(rem_q) - 1'b1)));

    a_r4_we_needs_select: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> $past(selected));

    a_r10_no_we_when_empty: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> ($past(rem_q) != '0));

    a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(load_count || ack_rise || cs_rise));

    a_r9_empty_is_idle: assert property (@(posedge clk) disable iff (rst)
        (rem_q == '0) |-> !dma_req);
endmodule

bind dma_tx_req_ctrl dmareq_checker #(.LEN_W(LEN_W)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .load_count (load_count),
    .load_len   (load_len),
    .dma_req    (dma_req),
    .fifo_we    (fifo_we),
    .rem_q      (rem_q),
    .hold_q     (hold_q),
    .selected   (cycle_selected),
    .ack_rise   (ack_rise),
    .cs_rise    (cs_rise),
    .wr_level   (lvl_wr_unused)
);

// File: tb/test_dma_tx_req_ctrl.sv
`timescale 1ns/1ps
module test_dma_tx_req_ctrl;
    localparam int LEN_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_strobe = 1'b0, dack = 1'b0, cs_strobe = 1'b0;
    logic load_count = 1'b0;
    logic [LEN_W-1:0] load_len = '0;
    logic dma_req, fifo_we;

    always #4 clk = ~clk;

    dma_tx_req_ctrl #(.LEN_W(LEN_W)) i_dma_tx_req_ctrl (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .dack(dack),
        .cs_strobe(cs_strobe), .load_count(load_count), .load_len(load_len),
        .dma_req(dma_req), .fifo_we(fifo_we)
    );

    int checks = 0, failures = 0, we_count = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // behavioural reference: strobe histories delayed two samples, then edge
    int m_rem = 0, m_pos = 0;
    bit m_req = 0, m_hold = 0, m_we = 0;
    bit hw[3], ha[3], hc[3];
    always @(posedge clk) begin
        if (rst) begin
            m_rem = 0; m_pos = 0; m_req = 0; m_hold = 0; m_we = 0;
            foreach (hw[i]) begin hw[i] = 0; ha[i] = 0; hc[i] = 0; end
        end else begin
            bit w_r, a_r, c_r, sel, acc;
            w_r = hw[1] && !hw[2];
            a_r = ha[1] && !ha[2];
            c_r = hc[1] && !hc[2];
            sel = ha[1] || hc[1];
            acc = w_r && sel && (m_rem > 0);
            m_we = 0;
            if (load_count) begin
                m_rem = int'(load_len); m_pos = 0; m_req = (load_len != 0); m_hold = 0;
            end else if (acc) begin
                m_we = 1;
                if (m_rem == 1) begin m_req = 0; m_hold = 0; end
                else if (m_rem == 2 || m_pos == 30) begin m_req = 0; m_hold = 1; end
                m_rem = m_rem - 1;
                m_pos = (m_pos + 1) % 32;
            end else if (m_hold && (a_r || c_r)) begin
                m_hold = 0;
                m_req = (m_rem > 1);
            end
            hw[2] = hw[1]; hw[1] = hw[0]; hw[0] = wr_strobe;
            ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = dack;
            hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = cs_strobe;
        end
    end

    // per-cycle comparison against the reference (R11 timing)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(dma_req === m_req, "R11 dma_req vs model", int'(dma_req), int'(m_req));
            chk(fifo_we === m_we, "R11 fifo_we vs model", int'(fifo_we), int'(m_we));
            if (fifo_we) we_count++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int n);
        @(negedge clk); load_count = 1; load_len = LEN_W'(n);
        @(negedge clk); load_count = 0;
        @(negedge clk);
    endtask

    task automatic bus_cycle(input bit a, input bit c);
        @(negedge clk); dack = a; cs_strobe = c;
        idle(4); wr_strobe = 1;
        idle(4); wr_strobe = 0;
        idle(4); dack = 0; cs_strobe = 0;
        idle(4);
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int base;
        idle(5);
        chk(dma_req === 0, "R1 req in reset", int'(dma_req), 0);
        chk(fifo_we === 0, "R1 we in reset", int'(fifo_we), 0);
        rst = 0;
        @(negedge clk);
        chk(dma_req === 0, "R1 req after reset", int'(dma_req), 0);

        load(0);
        chk(dma_req === 0, "R2 zero length leaves req low", int'(dma_req), 0);
        load(5);
        chk(dma_req === 1, "R2 nonzero length raises req", int'(dma_req), 1);

        base = we_count;
        bus_cycle(1, 0);
        chk(we_count == base + 1, "R3 ack write pulses we", we_count, base + 1);
        bus_cycle(1, 1);
        chk(we_count == base + 2, "R3 cs ignored under ack", we_count, base + 2);
        bus_cycle(1, 0);
        chk(dma_req === 1, "R5 req held before n-1", int'(dma_req), 1);
        bus_cycle(1, 0);
        chk(dma_req === 0, "R5 req drops at transfer n-1", int'(dma_req), 0);
        bus_cycle(1, 0);
        chk(we_count == base + 5, "R9 tail byte accepted", we_count, base + 5);
        chk(dma_req === 0, "R9 req stays low after last byte", int'(dma_req), 0);
        bus_cycle(1, 0);
        chk(we_count == base + 5, "R10 no write when empty", we_count, base + 5);
        chk(dma_req === 0, "R9 edge does not rearm after block", int'(dma_req), 0);

        load(3);
        base = we_count;
        bus_cycle(0, 0);
        chk(we_count == base, "R4 unselected write ignored", we_count, base);
        chk(dma_req === 1, "R4 req unaffected", int'(dma_req), 1);
        bus_cycle(0, 1);
        chk(we_count == base + 1, "R4 cs write accepted", we_count, base + 1);

        load(40);
        base = we_count;
        for (int i = 0; i < 30; i++) bus_cycle(1, 0);
        chk(dma_req === 1, "R6 req high through byte 30", int'(dma_req), 1);
        bus_cycle(1, 0);
        chk(dma_req === 0, "R6 req drops at byte 31", int'(dma_req), 0);
        bus_cycle(1, 0);
        chk(dma_req === 1, "R7 ack edge rearms", int'(dma_req), 1);
        for (int i = 0; i < 7; i++) bus_cycle(1, 0);
        chk(dma_req === 0, "R5 drop at byte 39 of 40", int'(dma_req), 0);
        bus_cycle(1, 0);
        chk(we_count == base + 40, "R3 forty bytes written", we_count, base + 40);
        chk(dma_req === 0, "R9 idle after long block", int'(dma_req), 0);

        load(34);
        for (int i = 0; i < 31; i++) bus_cycle(0, 1);
        chk(dma_req === 0, "R6 cs block drops at byte 31", int'(dma_req), 0);
        bus_cycle(0, 1);
        chk(dma_req === 1, "R8 cs edge rearms", int'(dma_req), 1);
        bus_cycle(0, 1);
        bus_cycle(0, 1);
        chk(dma_req === 0, "R9 cs block finished", int'(dma_req), 0);

        load(2);
        base = we_count;
        @(negedge clk); dack = 1;
        idle(4);
        for (int i = 0; i < 2; i++) begin
            wr_strobe = 1; idle(4);
            wr_strobe = 0; idle(4);
        end
        dack = 0; idle(4);
        chk(we_count == base + 2, "R9 fast tail byte accepted", we_count, base + 2);
        chk(dma_req === 0, "R9 req low after fast tail", int'(dma_req), 0);
        bus_cycle(1, 0);
        chk(dma_req === 0, "R9 no rearm after fast tail", int'(dma_req), 0);

        load(10);
        bus_cycle(1, 0);
        load(3);
        chk(dma_req === 1, "R2 reload arms", int'(dma_req), 1);
        bus_cycle(1, 0);
        bus_cycle(1, 0);
        chk(dma_req === 0, "R2 reload count used for n-1", int'(dma_req), 0);

        idle(4);
        summary();
    end
endmodule